// File: doc/BRIEF.md
# Tree Stem Router Direction Logic

This block picks the outgoing port for a packet header that reaches a stem router in one binary tree of a split mesh-of-trees network. Each row or column has its own tree of stem routers built above the leaf routers. The tree has no root router. The two routers at the highest stem level are joined to each other by a direct link. When a header arrives, the block takes the destination leaf index and the router's own level and position. It works out which router at the current level sits above that leaf. If that router is a different one, the packet has to leave this subtree. A router at the highest level sends it across the link to its neighbour, and a router at any lower level sends it up to its parent. If the current router is the right one, the packet has to go down, and one bit of the destination chooses the left or the right child.

The number of leaves per tree, `LEAVES`, is a parameter and must be a power of two of at least 4. The tree depth is D = log2(LEAVES), so 4 for the default of 16. Stem levels run from 1 up to the highest level T = D - 1. At level 1 the child ports lead straight to leaf routers. Routers at level l are numbered 0 upward, from left to right. The port choice is one-hot and appears one clock after the header strobe. Buffering and arbitration are handled around this block.

Top module: `stem_dir_router`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `out_valid` = 0 and `port_sel` = 0, whatever `hdr_valid` is.
- R2: `out_valid` is high in the cycle after a rising edge at which `hdr_valid` was high, and low in the cycle after an edge at which it was low.
- R3: At a valid level l, the target position is `dest_leaf >> l`. When `my_pos` equals it, the packet goes down through a child port: `port_sel` bit 2 (left) or bit 3 (right).
- R4: When going down from level l, bit l-1 of `dest_leaf` chooses the child: 0 selects left (`port_sel` = 4'b0100) and 1 selects right (`port_sel` = 4'b1000).
- R5: At a level l with 1 <= l < T, when `my_pos` differs from `dest_leaf >> l`, the parent port is chosen: `port_sel` = 4'b0001.
- R6: At the highest level l = T, when `my_pos` differs from `dest_leaf >> T`, the neighbour link is chosen: `port_sel` = 4'b0010. The parent port is never used at this level.
- R7: A header with `my_level` = 0 or `my_level` > T gives `out_valid` = 1 with `port_sel` = 0.
- R8: `port_sel` never has more than one bit set.
- R9: While `out_valid` is low, `port_sel` is 0. Changes to `dest_leaf`, `my_level` and `my_pos` without `hdr_valid` select no port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header strobe; the other inputs are sampled while it is high |
| dest_leaf | input | D | Destination leaf index within this tree |
| my_level | input | floor(log2 D)+1 | Stem level of this router (valid range 1..T) |
| my_pos | input | D | Position of this router within its level |
| port_sel | output | 4 | One-hot port choice: bit0 parent, bit1 neighbour, bit2 left child, bit3 right child |
| out_valid | output | 1 | The port choice is valid this cycle |

## Verification
The bench drives every combination of destination, level and position for 16 leaves. This covers the highest level, where a design that climbed instead of crossing would send packets to a root that does not exist. It also covers level 1, where choosing the child from the wrong destination bit would deliver to the sibling leaf. Level 0 and the levels above the highest level are swept as well, to catch designs that wrap the level or treat it as a valid shift. Idle cycles with changing inputs and a header held high through reset show whether the register leaks stale or unqualified port choices.

// File: rtl/stem_route_pkg.sv
// Shared definitions for the stem router direction logic.
// Port bit positions are fixed here because neighbouring blocks decode them.
package stem_route_pkg;

    localparam int NUM_PORTS = 4;
    localparam int P_PARENT  = 0;
    localparam int P_NEIGH   = 1;
    localparam int P_LEFT    = 2;
    localparam int P_RIGHT   = 3;

    // Kind of hop chosen for a header.
    typedef enum logic [1:0] {
        HOP_UP    = 2'd0,
        HOP_CROSS = 2'd1,
        HOP_DOWN  = 2'd2,
        HOP_NONE  = 2'd3
    } hop_dir_e;

    // Turn a hop kind and a child bit into a one-hot port vector.
    function automatic logic [NUM_PORTS-1:0] hop_to_port(input hop_dir_e dir,
                                                         input logic child_right);
        logic [NUM_PORTS-1:0] v;
        v = '0;
        case (dir)
            HOP_UP:    v[P_PARENT] = 1'b1;
            HOP_CROSS: v[P_NEIGH]  = 1'b1;
            HOP_DOWN:  begin
                if (child_right) v[P_RIGHT] = 1'b1;
                else             v[P_LEFT]  = 1'b1;
            end
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stem_level_target.sv
// Per-level target computation.
// Does: for the router's own level l it gives the index of the level-l router
// above the destination leaf (dest >> l) and the destination bit l-1, which
// chooses the child one level down. It also says whether l is a valid stem level.
// Assumes: levels run 1..TOP_LVL; all other values are flagged invalid.
module stem_level_target #(
    parameter int LEAF_W  = 4,
    parameter int LVL_W   = 3,
    parameter int TOP_LVL = 3
) (
    input  logic [LEAF_W-1:0] dest,
    input  logic [LVL_W-1:0]  level,
    output logic [LEAF_W-1:0] tgt_pos,
    output logic              child_bit,
    output logic              level_ok
);
    localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP_LVL);

    logic [LEAF_W-1:0] shifted [1:TOP_LVL];
    logic              childb  [1:TOP_LVL];

    // One fixed shift and one child bit for each stem level.
    for (genvar k = 1; k <= TOP_LVL; k++) begin : g_lvl
        assign shifted[k] = dest >> k;
        assign childb[k]  = dest[k-1];
    end

    // Pick the entries for the router's own level.
    always_comb begin
        tgt_pos   = '0;
        child_bit = 1'b0;
        for (int k = 1; k <= TOP_LVL; k++) begin
            if (level == LVL_W'(k)) begin
                tgt_pos   = shifted[k];
                child_bit = childb[k];
            end
        end
    end

    // A level is usable only inside the stem range.
    assign level_ok = (level != '0) && (level <= TOP_V);

endmodule

// File: rtl/stem_hop_decide.sv
// Hop decision.
// Does: compares the router's own position with the level target and picks
// climb (lower levels), cross (highest level) or descend, as a one-hot port vector.
// Assumes: the target and the child bit come from stem_level_target for the same level.
module stem_hop_decide
    import stem_route_pkg::*;
#(
    parameter int LEAF_W  = 4,
    parameter int LVL_W   = 3,
    parameter int TOP_LVL = 3
) (
    input  logic [LVL_W-1:0]     level,
    input  logic                 level_ok,
    input  logic [LEAF_W-1:0]    own_pos,
    input  logic [LEAF_W-1:0]    tgt_pos,
    input  logic                 child_bit,
    output hop_dir_e             dir,
    output logic [NUM_PORTS-1:0] port_next
);
    localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP_LVL);

    logic at_top;
    logic on_target;

    assign at_top    = (level == TOP_V);
    assign on_target = (own_pos == tgt_pos);

    // Choose the hop kind: down when on target, otherwise cross at the top level or climb.
    always_comb begin
        if (!level_ok)      dir = HOP_NONE;
        else if (on_target) dir = HOP_DOWN;
        else if (at_top)    dir = HOP_CROSS;
        else                dir = HOP_UP;
    end

    // Encode the hop kind into the port vector.
    assign port_next = hop_to_port(dir, child_bit);

endmodule

// File: rtl/stem_port_reg.sv
// Output register.
// Does: captures the port choice when the header strobe is high and clears
// it otherwise, so the outputs follow the strobe by exactly one cycle.
// Assumes: synchronous active-low reset.
module stem_port_reg #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [NPORT-1:0] port_next,
    output logic [NPORT-1:0] port_sel,
    output logic             out_valid
);
    // Register the qualified port choice and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_sel  <= '0;
            out_valid <= 1'b0;
        end else begin
            port_sel  <= hdr_valid ? port_next : '0;
            out_valid <= hdr_valid;
        end
    end

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (port_sel == '0));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));

endmodule

// File: rtl/stem_dir_router.sv
// Top level of the stem router direction logic.
// Does: for a header at a stem router of one row or column tree, gives the
// registered one-hot output port (parent, neighbour, left child, right child).
// Assumes: LEAVES is a power of two, at least 4; the highest stem level is
// log2(LEAVES)-1, where two routers are joined by a neighbour link instead of a root.
module stem_dir_router
    import stem_route_pkg::*;
#(
    parameter int LEAVES = 16,
    localparam int TREE_DEPTH = $clog2(LEAVES),
    localparam int TOP_LVL    = TREE_DEPTH - 1,
    localparam int LEAF_W     = TREE_DEPTH,
    localparam int LVL_W      = $clog2(TREE_DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  logic [LEAF_W-1:0]    dest_leaf,
    input  logic [LVL_W-1:0]     my_level,
    input  logic [LEAF_W-1:0]    my_pos,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic                 out_valid
);
    localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP_LVL);

    logic [LEAF_W-1:0]    tgt_pos;
    logic                 child_bit;
    logic                 level_ok;
    hop_dir_e             dir;
    logic [NUM_PORTS-1:0] port_next;

    // Target position and child bit for the router's own level.
    stem_level_target #(.LEAF_W(LEAF_W), .LVL_W(LVL_W), .TOP_LVL(TOP_LVL)) u_target (
        .dest      (dest_leaf),
        .level     (my_level),
        .tgt_pos   (tgt_pos),
        .child_bit (child_bit),
        .level_ok  (level_ok)
    );

    // Climb, cross or descend.
    stem_hop_decide #(.LEAF_W(LEAF_W), .LVL_W(LVL_W), .TOP_LVL(TOP_LVL)) u_decide (
        .level     (my_level),
        .level_ok  (level_ok),
        .own_pos   (my_pos),
        .tgt_pos   (tgt_pos),
        .child_bit (child_bit),
        .dir       (dir),
        .port_next (port_next)
    );

    // One-cycle output register.
    stem_port_reg #(.NPORT(NUM_PORTS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .port_next (port_next),
        .port_sel  (port_sel),
        .out_valid (out_valid)
    );

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !out_valid);

    assert_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && my_level != '0 && my_level <= TOP_V && (dest_leaf >> my_level) == my_pos)
        |=> (port_sel[P_LEFT] || port_sel[P_RIGHT]));

    assert_climb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && my_level != '0 && my_level < TOP_V && (dest_leaf >> my_level) != my_pos)
        |=> port_sel[P_PARENT]);

    assert_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && my_level == TOP_V && (dest_leaf >> my_level) != my_pos)
        |=> port_sel[P_NEIGH]);

    assert_top_no_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && my_level == TOP_V) |=> !port_sel[P_PARENT]);

    assert_bad_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (my_level == '0 || my_level > TOP_V)) |=> (port_sel == '0));

endmodule

// File: tb/stem_dir_router_tb.sv
`timescale 1ns/1ps
// Bench: full sweep of destination x level x position for 16 leaves.
module stem_dir_router_tb;
    localparam int LEAVES = 16;
    localparam int TOP    = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hdr_valid;
    logic [3:0] dest_leaf;
    logic [2:0] my_level;
    logic [3:0] my_pos;
    logic [3:0] port_sel;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    stem_dir_router #(.LEAVES(LEAVES)) u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
        .dest_leaf(dest_leaf), .my_level(my_level), .my_pos(my_pos),
        .port_sel(port_sel), .out_valid(out_valid)
    );

    // Expected port from the arithmetic rules of the requirements.
    function automatic logic [3:0] exp_port(int d, int l, int p);
        if (l == 0 || l > TOP) return 4'b0000;
        if ((d >> l) == p) return (((d >> (l - 1)) & 1) == 1) ? 4'b1000 : 4'b0100;
        if (l == TOP) return 4'b0010;
        return 4'b0001;
    endfunction

    function automatic string req_of(int d, int l, int p);
        if (l == 0 || l > TOP) return "R7";
        if ((d >> l) == p) return "R3 R4";
        if (l == TOP) return "R6";
        return "R5";
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hdr_valid = 1'b1; dest_leaf = 4'd5; my_level = 3'd1; my_pos = 4'd2;
        repeat (3) @(negedge clk);
        // R1: reset dominates a high header strobe
        chk("R1", {3'b0, out_valid}, 4'b0000);
        chk("R1", port_sel, 4'b0000);
        hdr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {3'b0, out_valid}, 4'b0000);

        for (int l = 0; l < 8; l++) begin
            for (int d = 0; d < 16; d++) begin
                for (int p = 0; p < 16; p++) begin
                    hdr_valid = 1'b1;
                    dest_leaf = 4'(d);
                    my_level  = 3'(l);
                    my_pos    = 4'(p);
                    @(negedge clk);
                    chk(req_of(d, l, p), port_sel, exp_port(d, l, p));
                    chk("R2", {3'b0, out_valid}, 4'b0001);
                    chk("R8", ($countones(port_sel) <= 1) ? 4'd1 : 4'd0, 4'd1);
                    if (((d + p) % 16) == 7) begin
                        // R9: inputs that would pick a port, but no strobe
                        hdr_valid = 1'b0;
                        dest_leaf = 4'(15 - d);
                        my_level  = 3'd1;
                        my_pos    = 4'(p);
                        @(negedge clk);
                        chk("R9", port_sel, 4'b0000);
                        chk("R2", {3'b0, out_valid}, 4'b0000);
                    end
                end
            end
        end

        // Back-to-back headers, then idle, around the highest level (R6, R4)
        hdr_valid = 1'b1; dest_leaf = 4'd9; my_level = 3'd3; my_pos = 4'd0;
        @(negedge clk);
        chk("R6", port_sel, 4'b0010);
        dest_leaf = 4'd9; my_level = 3'd1; my_pos = 4'd4;
        @(negedge clk);
        chk("R4", port_sel, 4'b1000);
        hdr_valid = 1'b0;
        @(negedge clk);
        chk("R9", port_sel, 4'b0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule